// File: doc/BRIEF.md
# Transmit Driver Performance Monitor

This block watches the signal that a line driver puts on the wire. Comparators on the two output legs report line activity as digital levels. The block samples those levels with a fast sampling clock. It treats any comparator pulse that is too narrow as a glitch. A pulse that stays high long enough counts as a mark.

A sampled copy of the transmit clock marks where each bit period ends. The block counts consecutive bit periods in which no mark was accepted. After a long run of empty periods it latches a zero-run alarm. That alarm clears on the next accepted mark or on a host clear command. A ground-fault indication on either output leg raises the alarm directly, and that cause releases by itself once both legs are clean. The block has two outputs: the alarm flag, and a two-bit cause field that tells which cause is active.

Top module: `dpm_monitor`

## Requirements
- R1: An accepted mark needs the OR of the comparator inputs to be high for at least MIN_W consecutive sampling-clock cycles (default 3). A shorter pulse is not a mark. A pulse of MIN_W cycles or longer counts as exactly one mark.
- R2: A bit period ends at each rising edge of `txclk_i`. The zero-run alarm sets when the period that closes is the ZERO_LIMIT-th (default 63) in a row without an accepted mark. After ZERO_LIMIT-1 such periods the alarm is still low.
- R3: An accepted mark clears the zero-run alarm within a few sampling cycles, before the bit period ends.
- R4: A one-cycle pulse on `host_clr_i` clears the zero-run alarm and restarts the zero count from zero. A new zero-run alarm then needs ZERO_LIMIT more empty periods.
- R5: A ground fault on either bit of `gnd_leg_i` drives `alarm_o` high within 3 sampling cycles. The alarm stays high while the fault is present, even across a host clear.
- R6: The ground-fault cause clears by itself within 3 cycles after both legs return low, with no clear command. A latched zero-run alarm is not affected by this.
- R7: `cause_o` bit 0 is the latched zero-run alarm and bit 1 is the ground-fault cause. `alarm_o` is high exactly when either bit is high.
- R8: The zero count saturates at ZERO_LIMIT, so a longer run keeps the alarm high. One accepted mark restarts the count, and a new alarm needs a full ZERO_LIMIT empty periods.
- R9: Any one of the N_CMP comparator inputs (default 4) counts as line activity.
- R10: After reset, `alarm_o` is 0 and `cause_o` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| txclk_i | input | 1 | Sampled transmit clock; its rising edge ends a bit period |
| cmp_i | input | N_CMP | Comparator line-activity levels |
| gnd_leg_i | input | N_LEGS | Ground-fault indication, one bit per output leg |
| host_clr_i | input | 1 | Host command that clears the zero-run alarm |
| alarm_o | output | 1 | Performance-monitor alarm |
| cause_o | output | 2 | Active cause: bit 0 zero run, bit 1 ground fault |

## Verification
Suppose the zero counter is off by one, or fails to restart on a mark or a clear. The alarm then rises one bit period early or late at the 63-period boundary. It would also stay low for a whole run after a saturated stretch. Either fault shows at `alarm_o` within about one bit period of the boundary.

Suppose the pulse-width counter is wrong. Then a glitch of MIN_W-1 cycles clears a latched alarm, or a pulse of exactly MIN_W cycles fails to clear it. Both show before the next transmit clock edge.

A wrong ground path shows on `cause_o` bit 1 within three sampling cycles of the leg changing.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

   localparam int CAUSE_W = 2;

   typedef struct packed {
      logic gnd;   // bit 1: live ground fault
      logic zrun;  // bit 0: latched zero run
   } dpm_cause_t;

   function automatic int cnt_width(input int limit);
      return $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/dpm_sync.sv
module dpm_sync #(
   parameter int W     = 1,
   parameter int DEPTH = 2
) (
   input  logic         clk_i,
   input  logic         rst_n_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (DEPTH == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [W-1:0] stage [DEPTH];
         for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_first
               always_ff @(posedge clk_i) begin
                  if (!rst_n_i) stage[i] <= '0;
                  else          stage[i] <= d_i;
               end
            end else begin : g_next
               always_ff @(posedge clk_i) begin
                  if (!rst_n_i) stage[i] <= '0;
                  else          stage[i] <= stage[i-1];
               end
            end
         end
         assign q_o = stage[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/dpm_glitch_filter.sv
module dpm_glitch_filter #(
   parameter int N_IN       = 4,
   parameter int MIN_W      = 3,
   parameter int SYNC_DEPTH = 2
) (
   input  logic            clk_i,
   input  logic            rst_n_i,
   input  logic [N_IN-1:0] cmp_i,
   output logic            mark_o
);

   localparam int RC_W = dpm_pkg::cnt_width(MIN_W);

   logic            act_raw;
   logic            act_s;
   logic [RC_W-1:0] run_cnt;

   // OR first, so skew between comparators cannot split one pulse
   assign act_raw = |cmp_i;

   dpm_sync #(.W(1), .DEPTH(SYNC_DEPTH)) u_sync (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .d_i     (act_raw),
      .q_o     (act_s)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         run_cnt <= '0;
         mark_o  <= 1'b0;
      end else begin
         mark_o <= act_s && (run_cnt == RC_W'(MIN_W - 1));
         if (!act_s)
            run_cnt <= '0;
         else if (run_cnt != RC_W'(MIN_W))
            run_cnt <= run_cnt + 1'b1;
      end
   end

   AST_ONE_MARK_PER_PULSE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      mark_o |=> !mark_o);  // R1
   AST_NO_MARK_FIRST_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $rose(act_s) |=> !mark_o);  // R1

endmodule

// File: rtl/dpm_zero_run.sv
module dpm_zero_run #(
   parameter int LIMIT = 63
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic txclk_i,
   input  logic mark_i,
   input  logic clr_i,
   output logic zalarm_o
);

   localparam int CW = dpm_pkg::cnt_width(LIMIT);

   logic          txclk_q;
   logic          tick;
   logic          mark_pend;
   logic          had_mark;
   logic [CW-1:0] cnt;

   assign tick     = txclk_i & ~txclk_q;
   assign had_mark = mark_pend | mark_i;

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         txclk_q   <= 1'b0;
         mark_pend <= 1'b0;
         cnt       <= '0;
         zalarm_o  <= 1'b0;
      end else begin
         txclk_q <= txclk_i;
         if (clr_i) begin
            mark_pend <= 1'b0;
            cnt       <= '0;
            zalarm_o  <= 1'b0;
         end else begin
            if (tick) begin
               mark_pend <= 1'b0;
               if (had_mark)
                  cnt <= '0;
               else if (cnt != CW'(LIMIT))
                  cnt <= cnt + 1'b1;
            end else if (mark_i) begin
               mark_pend <= 1'b1;
            end
            if (mark_i)
               zalarm_o <= 1'b0;
            else if (tick && !had_mark && cnt == CW'(LIMIT - 1))
               zalarm_o <= 1'b1;
         end
      end
   end

   AST_ALARM_AT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $rose(zalarm_o) |-> (cnt == CW'(LIMIT)));  // R2
   AST_MARK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      mark_i |=> !zalarm_o);  // R3
   AST_HOST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      clr_i |=> (!zalarm_o && cnt == '0));  // R4
   AST_CNT_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (cnt == CW'(LIMIT)) |=> (cnt == CW'(LIMIT) || cnt == '0));  // R8

endmodule

// File: rtl/dpm_monitor.sv
module dpm_monitor #(
   parameter int N_CMP      = 4,
   parameter int N_LEGS     = 2,
   parameter int MIN_W      = 3,
   parameter int ZERO_LIMIT = 63,
   parameter int SYNC_DEPTH = 2
) (
   input  logic                       clk_i,
   input  logic                       rst_n_i,
   input  logic                       txclk_i,
   input  logic [N_CMP-1:0]           cmp_i,
   input  logic [N_LEGS-1:0]          gnd_leg_i,
   input  logic                       host_clr_i,
   output logic                       alarm_o,
   output logic [dpm_pkg::CAUSE_W-1:0] cause_o
);

   generate
      if (MIN_W < 2)        begin : g_chk_w   $error("MIN_W must be at least 2");      end
      if (ZERO_LIMIT < 2)   begin : g_chk_lim $error("ZERO_LIMIT must be at least 2"); end
      if (N_CMP < 1)        begin : g_chk_cmp $error("N_CMP must be at least 1");      end
      if (N_LEGS < 1)       begin : g_chk_leg $error("N_LEGS must be at least 1");     end
      if (SYNC_DEPTH > 4)   begin : g_chk_syn $error("SYNC_DEPTH must not exceed 4");  end
   endgenerate

   logic               mark;
   logic               txclk_s;
   logic               zalarm;
   logic [N_LEGS-1:0]  gnd_s;
   dpm_pkg::dpm_cause_t cause;

   dpm_glitch_filter #(.N_IN(N_CMP), .MIN_W(MIN_W), .SYNC_DEPTH(SYNC_DEPTH)) u_filter (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .cmp_i   (cmp_i),
      .mark_o  (mark)
   );

   dpm_sync #(.W(1), .DEPTH(SYNC_DEPTH)) u_txclk_sync (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .d_i     (txclk_i),
      .q_o     (txclk_s)
   );

   dpm_sync #(.W(N_LEGS), .DEPTH(SYNC_DEPTH)) u_gnd_sync (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .d_i     (gnd_leg_i),
      .q_o     (gnd_s)
   );

   dpm_zero_run #(.LIMIT(ZERO_LIMIT)) u_zero_run (
      .clk_i    (clk_i),
      .rst_n_i  (rst_n_i),
      .txclk_i  (txclk_s),
      .mark_i   (mark),
      .clr_i    (host_clr_i),
      .zalarm_o (zalarm)
   );

   always_comb begin
      cause.zrun = zalarm;
      cause.gnd  = |gnd_s;
   end

   assign cause_o = cause;
   assign alarm_o = cause.zrun | cause.gnd;

   // cycles since reset, used to keep $past windows inside the reset-free span
   logic [1:0] settle_q;
   logic       gnd_any;
   assign gnd_any = |gnd_leg_i;

   always_ff @(posedge clk_i) begin
      if (!rst_n_i)            settle_q <= '0;
      else if (settle_q != 2'd3) settle_q <= settle_q + 1'b1;
   end

   AST_GND_RAISES: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (settle_q == 2'd3 && gnd_any && $past(gnd_any) && $past(gnd_any, 2)) |-> alarm_o);  // R5
   AST_GND_SELF_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (settle_q == 2'd3 && !gnd_any && !$past(gnd_any) && !$past(gnd_any, 2)) |-> !cause_o[1]);  // R6
   AST_ALARM_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      alarm_o |-> (cause_o != '0));  // R7

endmodule

// File: tb/tb_dpm_monitor.sv
module tb_dpm_monitor;

   localparam int MIN_W  = 3;
   localparam int LIMIT  = 63;
   localparam int HALF   = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       txclk = 1'b0;
   logic [3:0] cmp = '0;
   logic [1:0] gnd = '0;
   logic       clr = 1'b0;
   logic       alarm;
   logic [1:0] cause;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   dpm_monitor dut (
      .clk_i      (clk),
      .rst_n_i    (rst_n),
      .txclk_i    (txclk),
      .cmp_i      (cmp),
      .gnd_leg_i  (gnd),
      .host_clr_i (clr),
      .alarm_o    (alarm),
      .cause_o    (cause)
   );

   task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   // one bit period: low phase with optional pulse, then rising edge closes it
   task automatic send_bit(input int width, input int line);
      @(negedge clk);
      txclk = 1'b0;
      if (width > 0) begin
         cmp[line] = 1'b1;
         repeat (width) @(negedge clk);
         cmp[line] = 1'b0;
      end
      repeat (HALF - width) @(negedge clk);
      txclk = 1'b1;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic send_zeros(input int n);
      for (int i = 0; i < n; i++) send_bit(0, 0);
   endtask

   task automatic host_clear();
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R10 alarm after reset", {1'b0, alarm}, 2'b00);
      check("R10 cause after reset", cause, 2'b00);
   endtask

   task automatic t_zero_run();
      send_zeros(LIMIT - 1);
      check("R2 no alarm at 62 zeros", {1'b0, alarm}, 2'b00);
      send_zeros(1);
      check("R2 alarm at 63 zeros", {1'b0, alarm}, 2'b01);
      check("R7 zero-run cause", cause, 2'b01);
   endtask

   task automatic t_glitch();
      send_bit(MIN_W - 1, 0);
      check("R1 short pulse ignored", {1'b0, alarm}, 2'b01);
      send_bit(MIN_W, 2);
      check("R3 mark of MIN_W clears alarm", {1'b0, alarm}, 2'b00);
      check("R1 accepted mark cause", cause, 2'b00);
   endtask

   task automatic t_saturate();
      send_zeros(100);
      check("R8 alarm held past limit", {1'b0, alarm}, 2'b01);
      send_bit(MIN_W + 1, 3);
      check("R9 line 3 mark clears alarm", {1'b0, alarm}, 2'b00);
      send_zeros(LIMIT - 1);
      check("R8 count restarted, 62 zeros", {1'b0, alarm}, 2'b00);
      send_zeros(1);
      check("R8 alarm again at 63", {1'b0, alarm}, 2'b01);
   endtask

   task automatic t_host_clear();
      host_clear();
      check("R4 host clear drops alarm", {1'b0, alarm}, 2'b00);
      check("R4 host clear cause", cause, 2'b00);
      send_zeros(LIMIT - 1);
      check("R4 count restarted after clear", {1'b0, alarm}, 2'b00);
      send_zeros(1);
      check("R4 alarm after 63 more", {1'b0, alarm}, 2'b01);
   endtask

   task automatic t_ground();
      send_bit(MIN_W, 1);
      check("R3 mark before ground test", {1'b0, alarm}, 2'b00);
      @(negedge clk); gnd = 2'b01;
      repeat (3) @(negedge clk);
      check("R5 leg 0 ground alarm", {1'b0, alarm}, 2'b01);
      check("R7 ground cause", cause, 2'b10);
      gnd = 2'b00;
      repeat (3) @(negedge clk);
      check("R6 ground self clears", {1'b0, alarm}, 2'b00);
      gnd = 2'b10;
      repeat (3) @(negedge clk);
      check("R5 leg 1 ground alarm", {1'b0, alarm}, 2'b01);
      host_clear();
      check("R5 host clear keeps ground alarm", {1'b0, alarm}, 2'b01);
      gnd = 2'b00;
      repeat (3) @(negedge clk);
      check("R6 clear after leg 1 drops", cause, 2'b00);
   endtask

   task automatic t_both();
      send_zeros(LIMIT);
      @(negedge clk); gnd = 2'b10;
      repeat (3) @(negedge clk);
      check("R7 both causes", cause, 2'b11);
      gnd = 2'b00;
      repeat (3) @(negedge clk);
      check("R6 zero alarm kept after ground", cause, 2'b01);
      check("R6 alarm still high", {1'b0, alarm}, 2'b01);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_zero_run();
      t_glitch();
      t_saturate();
      t_host_clear();
      t_ground();
      t_both();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule